// File: doc/BRIEF.md
# Dual-Coil Latching Relay Pulse Controller

This block drives a relay with two coils: one coil moves the contacts to ON and the other moves them to OFF. The contacts stay where they are with no power applied. The controller never holds a coil energised to keep a state. For each change of state it energises exactly one coil for a fixed number of clock cycles, then releases both coils. It keeps its own copy of the contact position, together with a flag that says whether that copy can be trusted. From that copy it decides whether a request needs a pulse at all, because every pulse counts against the relay's mechanical life.

After a reset the surrounding system sends one initialisation command. The command carries the state the contacts should be in and a flag that says whether the hardware must be pulsed to make sure. A power loss or brownout needs that pulse, because the stored copy and the real contacts may disagree. A wake from a low-power mode does not, because nothing has moved the contacts. After that, ordinary set requests move the relay. Pulses run strictly one at a time, and a fixed quiet gap follows each pulse before the next one can start.

Top module: `latch_relay_pulser`

## Requirements
- R1: A pulse toward ON energises only `set_coil_o` and a pulse toward OFF energises only `reset_coil_o`. A state value of 1 means ON and 0 means OFF.
- R2: A coil pulse starts in the cycle after the command is accepted and lasts exactly `PULSE_CYC` cycles, where `PULSE_CYC` = `CLK_HZ` / 1000 * `PULSE_MS`.
- R3: `set_coil_o` and `reset_coil_o` are never high in the same cycle.
- R4: Outside a pulse both coil outputs are low. After synchronous reset, both coil outputs, `busy_o`, `done_o` and `state_valid_o` are low.
- R5: A request for the state already held, while `state_valid_o` is high, produces no pulse and raises `done_o` in the cycle after it is accepted.
- R6: While `state_valid_o` is low, a request always produces a pulse, even if it matches `state_o`.
- R7: An initialisation with the resync flag clear produces no pulse. In the next cycle `done_o` is high, `state_o` equals the given state and `state_valid_o` is high.
- R8: An initialisation with the resync flag set pulses the coil that matches the given state (SET for 1, RESET for 0). It then holds that state with `state_valid_o` high.
- R9: Requests and initialisations that arrive while `busy_o` is high are ignored. `busy_o` stays high from the cycle after acceptance until the gap ends.
- R10: After a pulse, `busy_o` stays high for exactly `GAP_CYC` cycles with both coils low, starting in the cycle the coil drops.
- R11: `done_o` is high for one cycle, in the cycle the coil drops. In that cycle `state_o` already shows the new state and `state_valid_o` is high.
- R12: If an initialisation and a request arrive in the same idle cycle, the initialisation is taken and the request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Set-request strobe |
| req_state | input | 1 | Requested contact state (1 = ON) |
| init_valid | input | 1 | Initialisation command strobe |
| init_state | input | 1 | State to hold after initialisation |
| init_resync | input | 1 | Pulse the hardware during initialisation |
| set_coil_o | output | 1 | Enable for the ON coil driver |
| reset_coil_o | output | 1 | Enable for the OFF coil driver |
| busy_o | output | 1 | Pulse or gap in progress; commands ignored |
| done_o | output | 1 | One-cycle completion strobe |
| state_o | output | 1 | Believed contact state |
| state_valid_o | output | 1 | Believed state is trustworthy |

## Verification
If the stored state or its validity flag goes wrong, it shows up as a pulse that is skipped or a pulse that is added. Either one can be seen at the coil pins in the cycle after the next request. A wrong value in the cycle counter shows as a coil high time or a quiet gap that is off by some cycles. That shows at the falling edge of the coil or of `busy_o`, at the latest within `PULSE_CYC` + `GAP_CYC` cycles. If the coil selection is wrong, the wrong pin is driven in the very first cycle of a pulse. The scoreboard then sees the wrong coil's width at the following `done_o`.

// File: rtl/relay_pulse_pkg.sv
package relay_pulse_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_PULSE = 2'd1,
        PH_GAP   = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        COIL_NONE = 2'd0,
        COIL_ON   = 2'd1,
        COIL_OFF  = 2'd2
    } coil_e;

endpackage

// File: rtl/rp_decide.sv
module rp_decide
    import relay_pulse_pkg::*;
(
    input  logic  idle,
    input  logic  init_valid,
    input  logic  init_state,
    input  logic  init_resync,
    input  logic  req_valid,
    input  logic  req_state,
    input  logic  held_state,
    input  logic  held_valid,
    output logic  accept,
    output logic  need_pulse,
    output logic  target,
    output coil_e coil
);

    always_comb begin
        accept = idle && (init_valid || req_valid);
        if (init_valid) begin
            // the initialisation command wins over a request in the same cycle
            target     = init_state;
            need_pulse = init_resync;
        end else begin
            target     = req_state;
            // an untrusted copy never allows a pulse to be skipped
            need_pulse = !held_valid || (req_state != held_state);
        end
        if (!need_pulse)  coil = COIL_NONE;
        else if (target)  coil = COIL_ON;
        else              coil = COIL_OFF;
    end

endmodule

// File: rtl/rp_coil_drive.sv
module rp_coil_drive
    import relay_pulse_pkg::*;
(
    input  coil_e coil,
    output logic  on_en,
    output logic  off_en
);

    always_comb begin
        on_en  = 1'b0;
        off_en = 1'b0;
        case (coil)
            COIL_ON:  on_en  = 1'b1;
            COIL_OFF: off_en = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/latch_relay_pulser.sv
module latch_relay_pulser
    import relay_pulse_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 50_000_000,
    parameter int unsigned PULSE_MS = 50,
    parameter int unsigned GAP_CYC  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_state,
    input  logic init_valid,
    input  logic init_state,
    input  logic init_resync,
    output logic set_coil_o,
    output logic reset_coil_o,
    output logic busy_o,
    output logic done_o,
    output logic state_o,
    output logic state_valid_o
);

    localparam int unsigned PULSE_CYC = CLK_HZ / 1000 * PULSE_MS;
    localparam int unsigned MAX_CYC   = (PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC;
    localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);

    typedef struct packed {
        phase_e            phase;
        coil_e             coil;
        logic [CNT_W-1:0]  cnt;
        logic              tgt;
        logic              st;
        logic              vld;
        logic              done;
    } ctl_t;

    ctl_t  ctl_d, ctl_q;
    logic  dec_accept, dec_pulse, dec_target;
    coil_e dec_coil;

    rp_decide u_decide (
        .idle        (ctl_q.phase == PH_IDLE),
        .init_valid  (init_valid),
        .init_state  (init_state),
        .init_resync (init_resync),
        .req_valid   (req_valid),
        .req_state   (req_state),
        .held_state  (ctl_q.st),
        .held_valid  (ctl_q.vld),
        .accept      (dec_accept),
        .need_pulse  (dec_pulse),
        .target      (dec_target),
        .coil        (dec_coil)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        case (ctl_q.phase)
            PH_IDLE: begin
                ctl_d.coil = COIL_NONE;
                if (dec_accept) begin
                    if (dec_pulse) begin
                        ctl_d.phase = PH_PULSE;
                        ctl_d.coil  = dec_coil;
                        ctl_d.cnt   = CNT_W'(PULSE_CYC - 1);
                        ctl_d.tgt   = dec_target;
                    end else begin
                        ctl_d.done = 1'b1;
                        ctl_d.st   = dec_target;
                        ctl_d.vld  = 1'b1;
                    end
                end
            end
            PH_PULSE: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.phase = PH_GAP;
                    ctl_d.coil  = COIL_NONE;
                    ctl_d.cnt   = CNT_W'(GAP_CYC - 1);
                    ctl_d.done  = 1'b1;
                    ctl_d.st    = ctl_q.tgt;
                    ctl_d.vld   = 1'b1;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            PH_GAP: begin
                ctl_d.coil = COIL_NONE;
                if (ctl_q.cnt == '0) ctl_d.phase = PH_IDLE;
                else                 ctl_d.cnt   = ctl_q.cnt - 1'b1;
            end
            default: begin
                ctl_d.phase = PH_IDLE;
                ctl_d.coil  = COIL_NONE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    rp_coil_drive u_drive (
        .coil   (ctl_q.coil),
        .on_en  (set_coil_o),
        .off_en (reset_coil_o)
    );

    assign busy_o        = (ctl_q.phase != PH_IDLE);
    assign done_o        = ctl_q.done;
    assign state_o       = ctl_q.st;
    assign state_valid_o = ctl_q.vld;

    // ---------------- assertions ----------------
    logic [CNT_W:0] hi_run;
    logic [CNT_W:0] lo_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run <= '0;
            lo_run <= (CNT_W+1)'(GAP_CYC);
        end else if (set_coil_o || reset_coil_o) begin
            hi_run <= hi_run + 1'b1;
            lo_run <= '0;
        end else begin
            hi_run <= '0;
            if (lo_run < (CNT_W+1)'(GAP_CYC)) lo_run <= lo_run + 1'b1;
        end
    end

    a_r3_coils_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_coil_o && reset_coil_o));

    a_r2_pulse_not_long: assert property (@(posedge clk) disable iff (!rst_n)
        (set_coil_o || reset_coil_o) |-> (hi_run < (CNT_W+1)'(PULSE_CYC)));

    a_r2_pulse_full_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(set_coil_o || reset_coil_o) |-> (hi_run == (CNT_W+1)'(PULSE_CYC)));

    a_r10_quiet_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(set_coil_o || reset_coil_o) |-> (lo_run >= (CNT_W+1)'(GAP_CYC)));

    a_r11_done_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(set_coil_o || reset_coil_o) |-> (done_o && state_valid_o));

    a_r5_skip_same: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && req_valid && !init_valid && state_valid_o && (req_state == state_o))
        |=> (done_o && !set_coil_o && !reset_coil_o));

    a_r6_invalid_pulses: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && req_valid && !init_valid && !state_valid_o)
        |=> (set_coil_o || reset_coil_o));

    a_r7_init_no_resync: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && init_valid && !init_resync)
        |=> (done_o && state_valid_o && (state_o == $past(init_state))));

    a_r9_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> (state_o == $past(state_o)) || done_o);

endmodule

// File: tb/latch_relay_pulser_tb.sv
module latch_relay_pulser_tb;

    localparam int P = 12;
    localparam int G = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_state = 1'b0;
    logic init_valid = 1'b0, init_state = 1'b0, init_resync = 1'b0;
    logic set_coil_o, reset_coil_o, busy_o, done_o, state_o, state_valid_o;

    always #2 clk = ~clk;

    latch_relay_pulser #(.CLK_HZ(1000), .PULSE_MS(P), .GAP_CYC(G)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_state(req_state),
        .init_valid(init_valid), .init_state(init_state), .init_resync(init_resync),
        .set_coil_o(set_coil_o), .reset_coil_o(reset_coil_o),
        .busy_o(busy_o), .done_o(done_o),
        .state_o(state_o), .state_valid_o(state_valid_o)
    );

    typedef struct packed { logic [1:0] coil; logic st; } exp_t;  // coil: 0 none, 1 SET, 2 RESET
    exp_t exp_q[$];
    int checks = 0, errors = 0;
    int on_cnt = 0, off_cnt = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // monitor: measures coil widths and compares against the queue at each done
    always @(negedge clk) begin
        if (!rst_n) begin
            on_cnt  = 0;
            off_cnt = 0;
        end else begin
            if (set_coil_o && reset_coil_o) chk(0, "R3 both coils high", 1, 0);
            if (set_coil_o)   on_cnt++;
            if (reset_coil_o) off_cnt++;
            if (done_o) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R9 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(on_cnt == ((e.coil == 2'd1) ? P : 0), "R1/R2/R8 SET coil cycles",
                        on_cnt, (e.coil == 2'd1) ? P : 0);
                    chk(off_cnt == ((e.coil == 2'd2) ? P : 0), "R1/R2/R8 RESET coil cycles",
                        off_cnt, (e.coil == 2'd2) ? P : 0);
                    chk(state_o == e.st, "R11 state at done", state_o, e.st);
                    chk(state_valid_o == 1'b1, "R11 valid at done", state_valid_o, 1);
                end
                on_cnt  = 0;
                off_cnt = 0;
            end
        end
    end

    task automatic clear_inputs();
        req_valid = 0; init_valid = 0; init_resync = 0;
    endtask

    task automatic issue(input bit is_init, input bit st, input bit rs,
                         input bit also_req, input bit rq_st,
                         input logic [1:0] ecoil, input bit est, input string tag);
        int n;
        while (busy_o) @(negedge clk);
        init_valid  = is_init;
        init_state  = st;
        init_resync = rs;
        req_valid   = !is_init || also_req;
        req_state   = is_init ? rq_st : st;
        exp_q.push_back(exp_t'{ecoil, est});
        @(negedge clk);
        clear_inputs();
        if (ecoil != 2'd0) begin
            chk(set_coil_o == (ecoil == 2'd1) && reset_coil_o == (ecoil == 2'd2),
                {tag, " R2 pulse begins next cycle"}, {set_coil_o, reset_coil_o}, ecoil);
            n = 0;
            while (!done_o && n < 1000) begin @(negedge clk); n++; end
            n = 0;
            while (busy_o && n < 1000) begin @(negedge clk); n++; end
            chk(n == G, {tag, " R10 gap length"}, n, G);
        end else begin
            chk(done_o && !set_coil_o && !reset_coil_o && !busy_o,
                {tag, " R5/R7 immediate done"}, done_o, 1);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!set_coil_o && !reset_coil_o, "R4 coils low in reset", {set_coil_o, reset_coil_o}, 0);
        chk(!busy_o && !done_o, "R4 idle in reset", {busy_o, done_o}, 0);
        chk(!state_valid_o, "R4 valid clear in reset", state_valid_o, 0);
        rst_n = 1;
        @(negedge clk);

        issue(0, 0, 0, 0, 0, 2'd2, 0, "R6 invalid OFF request");
        issue(0, 0, 0, 0, 0, 2'd0, 0, "R5 repeat OFF");
        issue(0, 1, 0, 0, 0, 2'd1, 1, "R1 ON request");
        issue(0, 1, 0, 0, 0, 2'd0, 1, "R5 repeat ON");
        issue(1, 0, 0, 0, 0, 2'd0, 0, "R7 init no resync");
        chk(state_o == 0 && state_valid_o, "R7 state after init", state_o, 0);
        issue(1, 1, 1, 0, 0, 2'd1, 1, "R8 init resync ON");
        issue(1, 0, 1, 1, 1, 2'd2, 0, "R12 init beats request");
        chk(state_o == 0, "R12 state from init", state_o, 0);

        // R9: commands during a pulse are dropped
        while (busy_o) @(negedge clk);
        req_valid = 1; req_state = 1;
        exp_q.push_back(exp_t'{2'd1, 1'b1});
        @(negedge clk);
        clear_inputs();
        chk(busy_o, "R9 busy during pulse", busy_o, 1);
        repeat (3) @(negedge clk);
        req_valid = 1; req_state = 0;
        init_valid = 1; init_state = 0; init_resync = 1;
        @(negedge clk);
        clear_inputs();
        while (busy_o) @(negedge clk);
        repeat (30) @(negedge clk);
        chk(state_o == 1, "R9 state kept after ignored commands", state_o, 1);
        chk(exp_q.size() == 0, "R9 no extra completion", exp_q.size(), 0);

        // synchronous reset clears validity; next request must pulse
        rst_n = 0;
        repeat (2) @(negedge clk);
        chk(!state_valid_o && !set_coil_o && !reset_coil_o, "R4 reset clears valid",
            state_valid_o, 0);
        rst_n = 1;
        @(negedge clk);
        issue(0, 0, 0, 0, 0, 2'd2, 0, "R6 request after reset");

        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R11 all completions seen", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule